// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

This block gathers up to eight interrupt request lines and presents the most urgent one to a processor on a single interrupt output. Software sets it up through an 8-bit host port with one address bit, a chip select and read and write strobes. A short sequence of setup words fixes the vector base, the cascade arrangement and the end-of-interrupt style. After setup, the same port loads the mask, issues end-of-interrupt commands and chooses which status register the even address returns.

The processor answers with two active-low acknowledge pulses. The first pulse commits the winning level to service. The second pulse returns an 8-bit vector, equal to the base plus the level number. Two instances form a two-level tree. The master drives a 3-bit cascade code for any input that has a slave behind it. Only the slave whose identity matches that code returns the vector.

All inputs are sampled on the rising edge of `clk`, which is the only clock. Reset is synchronous and active high.

Top module: `prio_irq_ctrl`

## Requirements
- R1: An even-address write with data bit 4 set starts setup. The next odd-address write is the vector base. If bit 1 of the first word was clear, a cascade word follows. If bit 0 was set, a mode word follows. After that, odd-address writes load the mask.
- R2: On the second acknowledge pulse a selected controller drives `dout` with the base plus the winning level and raises `dout_oe` for as long as that pulse lasts.
- R3: An odd-address write loads the mask after setup, and an odd-address read returns it. A mask bit of 1 keeps its input off `int_out`, but its request is still recorded.
- R4: An even-address write of 0x0A makes even-address reads return the request register, and 0x0B makes them return the in-service register. The choice holds until it is changed.
- R5: Level 0 has the highest priority and level 7 the lowest. `int_out` is high only while an unmasked request exists and no level of equal or higher priority is in service.
- R6: On the first acknowledge pulse the winning level gets its in-service bit set and its request bit cleared.
- R7: An even-address write of 0x60 plus n (n in bits 2:0) clears in-service bit n and no other bit.
- R8: An even-address write of 0x20 clears the highest-priority in-service bit that is set.
- R9: If a request falls before the acknowledge, the cycle still finishes with the vector for level 7 and no in-service bit is set.
- R10: When bit 1 of the mode word is set, the in-service bit of the served level clears at the second acknowledge pulse, with no command needed.
- R11: In cascade mode the master puts the level number on `cas_out` with `cas_oe` high for any input marked in its cascade bitmap, and it does not drive the vector. A slave returns its vector only when `cas_in` equals its 3-bit identity. The master puts 0 on `cas_out` for its own inputs.
- R12: Reset or a new setup start clears the request, in-service and mask registers and selects the request register for even-address reads.
- R13: A request is latched on a rising edge of its input and dropped if the input goes low. An input that stays high after service does not raise a new request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; acts on its falling edge |
| a0 | input | 1 | Register address select |
| din | input | 8 | Host write data |
| dout | output | 8 | Read data or vector |
| dout_oe | output | 1 | High while `dout` carries read data or a vector |
| irq_in | input | 8 | Interrupt request lines, level 0 highest |
| int_out | output | 1 | Interrupt request to the processor |
| inta_n | input | 1 | Acknowledge pulses, active low |
| is_master | input | 1 | High for the master of a cascade |
| cas_in | input | 3 | Cascade code seen by a slave |
| cas_out | output | 3 | Cascade code driven by a master |
| cas_oe | output | 1 | High while `cas_out` is valid |

## Verification
The hardest state to reach is a two-level acknowledge. In it the master must commit its cascade input on the first pulse and hold the code across both pulses. Meanwhile the slave has to wait for the second pulse before it commits its own in-service bit and drives the vector. The bench wires a second instance as a slave. The slave's `int_out` feeds the master's level 2 and the master's cascade code feeds the slave. The bench raises a slave input and follows it through both pulses, reading back both in-service registers. The spurious case is reached by raising a request, waiting for `int_out`, and dropping the request before the first pulse.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    ST_READY = 2'd0,
    ST_WBASE = 2'd1,
    ST_WCASC = 2'd2,
    ST_WMODE = 2'd3
  } init_st_t;

  localparam logic [2:0] OP_SPEC_EOI = 3'b011;
  localparam logic [2:0] OP_NS_EOI   = 3'b001;
endpackage

// File: rtl/pic_pri_enc.sv
module pic_pri_enc #(
  parameter int N = 8,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] req,
  output logic         hit,
  output logic [W-1:0] idx
);
  always_comb begin
    hit = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = W'(i);
    end
  end
endmodule

// File: rtl/pic_host_if.sv
module pic_host_if
  import pic_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LVL_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              a0,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] base_q,
  output logic [DATA_W-1:0] casc_q,
  output logic              single_q,
  output logic              aeoi_q,
  output logic              sel_isr_q,
  output logic              init_go,
  output logic              eoi_spec,
  output logic              eoi_ns,
  output logic [LVL_W-1:0]  eoi_lvl
);
  init_st_t st_q;
  logic     wr_q;
  logic     need_mode_q;
  logic     wr_fall;
  logic     ocw2;

  always_comb begin
    wr_fall  = wr_q & ~wr_n & ~cs_n;
    init_go  = wr_fall & ~a0 & din[4];
    ocw2     = wr_fall & ~a0 & ~din[4] & ~din[3];
    eoi_spec = ocw2 && (din[7:5] == OP_SPEC_EOI);
    eoi_ns   = ocw2 && (din[7:5] == OP_NS_EOI);
    eoi_lvl  = din[LVL_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q        <= 1'b1;
      st_q        <= ST_READY;
      mask_q      <= '0;
      base_q      <= '0;
      casc_q      <= '0;
      single_q    <= 1'b1;
      aeoi_q      <= 1'b0;
      sel_isr_q   <= 1'b0;
      need_mode_q <= 1'b0;
    end else begin
      wr_q <= wr_n;
      if (init_go) begin
        st_q        <= ST_WBASE;
        need_mode_q <= din[0];
        single_q    <= din[1];
        mask_q      <= '0;
        sel_isr_q   <= 1'b0;
        aeoi_q      <= 1'b0;
      end else if (wr_fall && !a0 && din[3]) begin
        if (din[1]) sel_isr_q <= din[0];
      end else if (wr_fall && a0) begin
        case (st_q)
          ST_WBASE: begin
            base_q <= din;
            if (!single_q)        st_q <= ST_WCASC;
            else if (need_mode_q) st_q <= ST_WMODE;
            else                  st_q <= ST_READY;
          end
          ST_WCASC: begin
            casc_q <= din;
            st_q   <= need_mode_q ? ST_WMODE : ST_READY;
          end
          ST_WMODE: begin
            aeoi_q <= din[1];
            st_q   <= ST_READY;
          end
          default: mask_q <= din;
        endcase
      end
    end
  end
endmodule

// File: rtl/pic_core.sv
module pic_core #(
  parameter int DATA_W = 8,
  parameter int LVL_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] irq_in,
  input  logic              inta_n,
  input  logic              is_master,
  input  logic [LVL_W-1:0]  cas_in,
  input  logic [DATA_W-1:0] mask_q,
  input  logic [DATA_W-1:0] base_q,
  input  logic [DATA_W-1:0] casc_q,
  input  logic              single_q,
  input  logic              aeoi_q,
  input  logic              init_go,
  input  logic              eoi_spec,
  input  logic              eoi_ns,
  input  logic [LVL_W-1:0]  eoi_lvl,
  output logic [DATA_W-1:0] irr_q,
  output logic [DATA_W-1:0] isr_q,
  output logic              int_q,
  output logic [LVL_W-1:0]  cas_out_q,
  output logic              cas_oe_q,
  output logic              inta_fall,
  output logic              vec_go,
  output logic [DATA_W-1:0] vec_val
);
  localparam logic [LVL_W-1:0] SPUR_LVL = LVL_W'(DATA_W - 1);

  logic [DATA_W-1:0] irq_q;
  logic              inta_q;
  logic              phase_q;
  logic [LVL_W-1:0]  lat_lvl_q;
  logic              lat_real_q;

  logic [DATA_W-1:0] pend;
  logic              p_hit, s_hit;
  logic [LVL_W-1:0]  p_idx, s_idx;
  logic              pend_ok, master_like, first, second, sel2;
  logic [DATA_W-1:0] irr_n, isr_n;

  assign pend = irr_q & ~mask_q;

  pic_pri_enc #(.N(DATA_W), .W(LVL_W)) u_enc_req (.req(pend),  .hit(p_hit), .idx(p_idx));
  pic_pri_enc #(.N(DATA_W), .W(LVL_W)) u_enc_srv (.req(isr_q), .hit(s_hit), .idx(s_idx));

  always_comb begin
    pend_ok     = p_hit && (!s_hit || (p_idx < s_idx));
    master_like = is_master | single_q;
    inta_fall   = inta_q & ~inta_n;
    first       = inta_fall & ~phase_q;
    second      = inta_fall & phase_q;
    if (master_like) sel2 = !(lat_real_q && !single_q && casc_q[lat_lvl_q]);
    else             sel2 = (cas_in == casc_q[LVL_W-1:0]);
    vec_go  = second & sel2;
    vec_val = base_q + DATA_W'(lat_lvl_q);
  end

  always_comb begin
    irr_n = (irr_q | (irq_in & ~irq_q)) & irq_in;
    isr_n = isr_q;
    if (first && master_like && pend_ok) begin
      isr_n[p_idx] = 1'b1;
      irr_n[p_idx] = 1'b0;
    end
    if (second && !master_like && sel2 && lat_real_q) begin
      irr_n[lat_lvl_q] = 1'b0;
      if (!aeoi_q) isr_n[lat_lvl_q] = 1'b1;
    end
    if (second && master_like && aeoi_q && lat_real_q) isr_n[lat_lvl_q] = 1'b0;
    if (eoi_spec) isr_n[eoi_lvl] = 1'b0;
    if (eoi_ns && s_hit) isr_n[s_idx] = 1'b0;
    if (init_go) begin
      irr_n = '0;
      isr_n = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q      <= '0;
      inta_q     <= 1'b1;
      phase_q    <= 1'b0;
      lat_lvl_q  <= '0;
      lat_real_q <= 1'b0;
      irr_q      <= '0;
      isr_q      <= '0;
      int_q      <= 1'b0;
      cas_out_q  <= '0;
      cas_oe_q   <= 1'b0;
    end else begin
      irq_q  <= irq_in;
      inta_q <= inta_n;
      irr_q  <= irr_n;
      isr_q  <= isr_n;
      int_q  <= pend_ok & ~init_go;
      if (first) begin
        phase_q    <= 1'b1;
        lat_lvl_q  <= pend_ok ? p_idx : SPUR_LVL;
        lat_real_q <= pend_ok;
        if (is_master && !single_q && pend_ok && casc_q[p_idx]) begin
          cas_out_q <= p_idx;
          cas_oe_q  <= 1'b1;
        end else begin
          cas_out_q <= '0;
          cas_oe_q  <= 1'b0;
        end
      end else if (second) begin
        phase_q <= 1'b0;
      end else if (!phase_q && inta_n) begin
        cas_out_q <= '0;
        cas_oe_q  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int DATA_W = 8,
  parameter int LVL_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              a0,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe,
  input  logic [DATA_W-1:0] irq_in,
  output logic              int_out,
  input  logic              inta_n,
  input  logic              is_master,
  input  logic [LVL_W-1:0]  cas_in,
  output logic [LVL_W-1:0]  cas_out,
  output logic              cas_oe
);
  logic [DATA_W-1:0] mask_q, base_q, casc_q, irr_q, isr_q, vec_val, rd_data;
  logic              single_q, aeoi_q, sel_isr_q, init_go, eoi_spec, eoi_ns;
  logic              inta_fall, vec_go, vhold_q;
  logic [LVL_W-1:0]  eoi_lvl;

  pic_host_if #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_host (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .a0(a0), .din(din),
    .mask_q(mask_q), .base_q(base_q), .casc_q(casc_q), .single_q(single_q),
    .aeoi_q(aeoi_q), .sel_isr_q(sel_isr_q), .init_go(init_go),
    .eoi_spec(eoi_spec), .eoi_ns(eoi_ns), .eoi_lvl(eoi_lvl)
  );

  pic_core #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_core (
    .clk(clk), .rst(rst), .irq_in(irq_in), .inta_n(inta_n),
    .is_master(is_master), .cas_in(cas_in), .mask_q(mask_q), .base_q(base_q),
    .casc_q(casc_q), .single_q(single_q), .aeoi_q(aeoi_q), .init_go(init_go),
    .eoi_spec(eoi_spec), .eoi_ns(eoi_ns), .eoi_lvl(eoi_lvl),
    .irr_q(irr_q), .isr_q(isr_q), .int_q(int_out), .cas_out_q(cas_out),
    .cas_oe_q(cas_oe), .inta_fall(inta_fall), .vec_go(vec_go), .vec_val(vec_val)
  );

  assign rd_data = a0 ? mask_q : (sel_isr_q ? isr_q : irr_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= '0;
      dout_oe <= 1'b0;
      vhold_q <= 1'b0;
    end else if (vec_go) begin
      dout    <= vec_val;
      dout_oe <= 1'b1;
      vhold_q <= 1'b1;
    end else if (vhold_q && !inta_n) begin
      dout_oe <= 1'b1;
    end else if (!cs_n && !rd_n) begin
      dout    <= rd_data;
      dout_oe <= 1'b1;
      vhold_q <= 1'b0;
    end else begin
      dout_oe <= 1'b0;
      vhold_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pic_chk.sv
module pic_chk #(
  parameter int DATA_W = 8,
  parameter int LVL_W  = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              rd_n,
  input logic              inta_n,
  input logic              is_master,
  input logic              dout_oe,
  input logic              cas_oe,
  input logic              int_out,
  input logic              init_go,
  input logic              eoi_spec,
  input logic [LVL_W-1:0]  eoi_lvl,
  input logic              inta_fall,
  input logic [DATA_W-1:0] irr_q,
  input logic [DATA_W-1:0] isr_q,
  input logic [DATA_W-1:0] mask_q
);
  a_r12_init_clears: assert property (@(posedge clk) disable iff (rst)
    init_go |=> (irr_q == '0 && isr_q == '0 && mask_q == '0));

  a_r6_isr_only_on_ack: assert property (@(posedge clk) disable iff (rst)
    (|(isr_q & ~$past(isr_q))) |-> $past(inta_fall));

  a_r7_spec_eoi_clears: assert property (@(posedge clk) disable iff (rst)
    (eoi_spec && !inta_fall) |=> !isr_q[$past(eoi_lvl)]);

  a_r5_int_needs_request: assert property (@(posedge clk) disable iff (rst)
    int_out |-> $past(|(irr_q & ~mask_q)));

  a_r2_oe_has_cause: assert property (@(posedge clk) disable iff (rst)
    dout_oe |-> ($past(!cs_n && !rd_n) || $past(!inta_n)));

  a_r11_cas_from_master: assert property (@(posedge clk) disable iff (rst)
    cas_oe |-> is_master);
endmodule

bind prio_irq_ctrl pic_chk #(.DATA_W(DATA_W), .LVL_W(LVL_W)) chk_i (
  .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .inta_n(inta_n),
  .is_master(is_master), .dout_oe(dout_oe), .cas_oe(cas_oe), .int_out(int_out),
  .init_go(init_go), .eoi_spec(eoi_spec), .eoi_lvl(eoi_lvl),
  .inta_fall(inta_fall), .irr_q(irr_q), .isr_q(isr_q), .mask_q(mask_q)
);

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_m = 1'b1, cs_s = 1'b1, rd_n = 1'b1, wr_n = 1'b1, a0 = 1'b0;
  logic [7:0] din = '0;
  logic       inta_n = 1'b1;
  logic [7:0] irq_m = '0, irq_s = '0;
  logic [7:0] dout_m, dout_s, irq_m_full;
  logic       oe_m, oe_s, int_m, int_s, cas_oe_m, cas_oe_s;
  logic [2:0] cas_m, cas_s;
  int         total = 0, bad = 0;
  bit         done = 0;

  logic [7:0] r_m, r_s, av_m, av_s;
  logic       ao_m, ao_s, a_caso;
  logic [2:0] a_cas;

  always #(CLK_P/2) clk = ~clk;

  assign irq_m_full = {irq_m[7:3], int_s, irq_m[1:0]};

  prio_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_m), .rd_n(rd_n), .wr_n(wr_n), .a0(a0),
    .din(din), .dout(dout_m), .dout_oe(oe_m), .irq_in(irq_m_full),
    .int_out(int_m), .inta_n(inta_n), .is_master(1'b1), .cas_in(3'd0),
    .cas_out(cas_m), .cas_oe(cas_oe_m));

  prio_irq_ctrl dut_s (
    .clk(clk), .rst(rst), .cs_n(cs_s), .rd_n(rd_n), .wr_n(wr_n), .a0(a0),
    .din(din), .dout(dout_s), .dout_oe(oe_s), .irq_in(irq_s),
    .int_out(int_s), .inta_n(inta_n), .is_master(1'b0), .cas_in(cas_m),
    .cas_out(cas_s), .cas_oe(cas_oe_s));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input bit slave, input bit addr, input logic [7:0] d);
    @(negedge clk);
    if (slave) cs_s = 1'b0; else cs_m = 1'b0;
    a0 = addr; din = d; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1; cs_m = 1'b1; cs_s = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(input bit slave, input bit addr, output logic [7:0] d);
    @(negedge clk);
    if (slave) cs_s = 1'b0; else cs_m = 1'b0;
    a0 = addr; rd_n = 1'b0;
    @(negedge clk);
    d = slave ? dout_s : dout_m;
    rd_n = 1'b1; cs_m = 1'b1; cs_s = 1'b1;
    @(negedge clk);
  endtask

  task automatic ack();
    @(negedge clk); inta_n = 1'b0;
    @(negedge clk); inta_n = 1'b1;
    @(negedge clk); inta_n = 1'b0;
    @(negedge clk);
    av_m = dout_m; ao_m = oe_m; av_s = dout_s; ao_s = oe_s;
    a_cas = cas_m; a_caso = cas_oe_m;
    inta_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic setup(input bit slave, input logic [7:0] w1, input logic [7:0] w2,
                       input logic [7:0] w3, input logic [7:0] w4);
    wr(slave, 1'b0, w1);
    wr(slave, 1'b1, w2);
    if (!w1[1]) wr(slave, 1'b1, w3);
    if (w1[0]) wr(slave, 1'b1, w4);
  endtask

  task automatic t_reset();
    check("R12 int after reset", int_m, 0);
    rd(0, 1, r_m); check("R12 mask after reset", r_m, 8'h00);
    rd(0, 0, r_m); check("R12 request reg after reset", r_m, 8'h00);
  endtask

  task automatic t_short_setup();
    setup(0, 8'h12, 8'h40, 8'h00, 8'h00);
    wr(0, 1, 8'h55);
    rd(0, 1, r_m); check("R1 odd write after two-word setup is mask", r_m, 8'h55);
    wr(0, 1, 8'h00);
  endtask

  task automatic t_basic();
    setup(0, 8'h13, 8'h30, 8'h00, 8'h01);
    irq_m[5] = 1'b1; idle(4);
    check("R5 int raised", int_m, 1);
    ack();
    check("R2 vector level 5", av_m, 8'h35);
    check("R2 vector enable", ao_m, 1);
    wr(0, 0, 8'h0B); rd(0, 0, r_m); check("R6 in-service set", r_m, 8'h20);
    check("R5 int dropped in service", int_m, 0);
    wr(0, 0, 8'h0A); rd(0, 0, r_m); check("R6 request cleared", r_m, 8'h00);
    wr(0, 0, 8'h0B);
    wr(0, 0, 8'h65); rd(0, 0, r_m); check("R7 specific eoi", r_m, 8'h00);
    rd(0, 0, r_m); check("R4 selection persists", r_m, 8'h00);
    idle(3); check("R13 held input no new request", int_m, 0);
    wr(0, 0, 8'h0A); rd(0, 0, r_m); check("R13 request reg stays empty", r_m, 8'h00);
    irq_m[5] = 1'b0; idle(2);
  endtask

  task automatic t_priority();
    irq_m[4] = 1'b1; irq_m[1] = 1'b1; idle(4);
    ack(); check("R5 higher level wins", av_m, 8'h31);
    idle(2); check("R5 lower level blocked", int_m, 0);
    irq_m[0] = 1'b1; idle(4);
    check("R5 higher level preempts", int_m, 1);
    ack(); check("R2 vector level 0", av_m, 8'h30);
    wr(0, 0, 8'h0B); rd(0, 0, r_m); check("R6 nested in-service", r_m, 8'h03);
    wr(0, 0, 8'h20); rd(0, 0, r_m); check("R8 nonspecific clears level 0", r_m, 8'h02);
    idle(2); check("R5 still blocked by level 1", int_m, 0);
    wr(0, 0, 8'h20); rd(0, 0, r_m); check("R8 nonspecific clears level 1", r_m, 8'h00);
    idle(2); check("R5 level 4 now presented", int_m, 1);
    ack(); check("R2 vector level 4", av_m, 8'h34);
    wr(0, 0, 8'h62);
    rd(0, 0, r_m); check("R7 other bit untouched", r_m, 8'h10);
    wr(0, 0, 8'h64);
    irq_m[0] = 1'b0; irq_m[1] = 1'b0; irq_m[4] = 1'b0; idle(2);
  endtask

  task automatic t_mask();
    wr(0, 1, 8'h08);
    rd(0, 1, r_m); check("R3 mask readback", r_m, 8'h08);
    irq_m[3] = 1'b1; idle(4);
    check("R3 masked input silent", int_m, 0);
    wr(0, 0, 8'h0A); rd(0, 0, r_m); check("R3 masked request recorded", r_m, 8'h08);
    wr(0, 1, 8'h00); idle(3);
    check("R3 unmask presents", int_m, 1);
    ack(); check("R3 vector after unmask", av_m, 8'h33);
    wr(0, 0, 8'h63);
    irq_m[3] = 1'b0; idle(2);
  endtask

  task automatic t_spurious();
    irq_m[6] = 1'b1; idle(4);
    check("R9 int before drop", int_m, 1);
    irq_m[6] = 1'b0; idle(2);
    ack(); check("R9 spurious vector", av_m, 8'h37);
    wr(0, 0, 8'h0B); rd(0, 0, r_m); check("R9 no in-service bit", r_m, 8'h00);
  endtask

  task automatic t_reinit_aeoi();
    wr(0, 1, 8'hAA);
    irq_m[1] = 1'b1; idle(3);
    setup(0, 8'h13, 8'h30, 8'h00, 8'h03);
    rd(0, 1, r_m); check("R12 setup clears mask", r_m, 8'h00);
    rd(0, 0, r_m); check("R12 setup clears requests", r_m, 8'h00);
    irq_m[1] = 1'b0;
    irq_m[6] = 1'b1; idle(4);
    rd(0, 0, r_m); check("R12 request register selected", r_m, 8'h40);
    ack(); check("R10 vector", av_m, 8'h36);
    wr(0, 0, 8'h0B); rd(0, 0, r_m); check("R10 auto clear", r_m, 8'h00);
    check("R10 int low", int_m, 0);
    irq_m[6] = 1'b0; idle(2);
  endtask

  task automatic t_cascade();
    setup(0, 8'h11, 8'h30, 8'h04, 8'h01);
    setup(1, 8'h11, 8'h38, 8'h02, 8'h01);
    irq_s[3] = 1'b1; idle(8);
    check("R11 master int from slave", int_m, 1);
    ack();
    check("R11 cascade code", a_cas, 3'd2);
    check("R11 cascade enable", a_caso, 1);
    check("R11 master silent", ao_m, 0);
    check("R11 slave enable", ao_s, 1);
    check("R11 slave vector", av_s, 8'h3B);
    wr(0, 0, 8'h0B); rd(0, 0, r_m); check("R11 master in-service", r_m, 8'h04);
    wr(1, 0, 8'h0B); rd(1, 0, r_s); check("R11 slave in-service", r_s, 8'h08);
    wr(1, 0, 8'h63); wr(0, 0, 8'h62);
    rd(1, 0, r_s); check("R7 slave eoi", r_s, 8'h00);
    rd(0, 0, r_m); check("R7 master eoi", r_m, 8'h00);
    irq_s[3] = 1'b0;
    irq_m[0] = 1'b1; idle(4);
    ack();
    check("R11 own input vector", av_m, 8'h30);
    check("R11 no code for own input", a_caso, 0);
    check("R11 slave not selected", ao_s, 0);
    wr(0, 0, 8'h60);
    irq_m[0] = 1'b0; idle(2);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    idle(2);
    t_reset();
    t_short_setup();
    t_basic();
    t_priority();
    t_mask();
    t_spurious();
    t_reinit_aeoi();
    t_cascade();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule